// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer with Compare, Capture and Waveform Output

This block is a wide up-counter driven by the functional clock. Software writes a start value into the counter, sets the run bit, and the counter steps upward once per tick. A tick is either every clock or, with the prescaler on, one clock in every 2^(ratio+1). When the counter passes its all-ones value it raises an overflow event. It then either reloads from a load register or halts and drops its own run bit. A compare register can flag the tick on which the counter holds a chosen value. An external input, after synchronisation, can latch the running count on a rising edge, a falling edge or either edge.

Overflow, compare and capture events set three sticky status bits that software clears by writing ones. Each source reaches the interrupt line only while its enable bit is set. Enables are changed through a pair of set and clear addresses. One output pin either follows a static level or reacts to the counter: it toggles or pulses on overflow events alone, or on both overflow and compare events. The register port is a plain single-cycle write strobe with a combinational read, all in the functional clock domain.

Top module: `cmp_cap_timer`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, the output pin is low and the interrupt is low. Word addresses: 0 control, 1 counter, 2 load, 3 compare, 4 capture (read-only), 5 status, 6 enable-set, 7 enable-clear. Addresses 6 and 7 both read back the enable mask.
- R2: While control bit 0 (run) is set, the counter advances by one on every tick, starting from the value last written to address 1. A counter write takes priority over a tick in the same cycle.
- R3: Control bit 5 turns on the prescaler, and control bits [4:2] hold the ratio r. With the prescaler on, one tick occurs every 2^(r+1) clocks, counted from the control write.
- R4: A tick taken while the counter is all ones sets status bit 1. If control bit 1 (auto-reload) is set, the counter takes the load value and keeps running. If it is clear, the counter becomes zero and run is cleared by hardware.
- R5: While control bit 6 is set, a tick taken while the counter equals the compare register sets status bit 0. With bit 6 clear, no compare flag is raised.
- R6: Control bits [9:8] select the capture edge of the synchronised input: 01 rising, 10 falling, 11 both, 00 none. A selected edge copies the counter into the capture register and sets status bit 2. Edges that are not selected change neither.
- R7: When control bit 13 is set, a capture edge that arrives while status bit 2 is still set raises the flag but leaves the capture register unchanged.
- R8: Control bits [11:10] choose the output event: 0 none, 1 overflow only, 2 overflow or compare (3 behaves as 0). With control bit 12 set, the pin inverts on each event. With bit 12 clear, the pin is inverted for the single clock after an event. Writing the control register clears the toggle state.
- R9: Control bit 7 is the pin's idle level. Control bit 14 forces the pin to bit 7 regardless of events.
- R10: Writing address 5 clears each status bit written as 1 and leaves bits written as 0. A hardware event in the same cycle wins over the clear.
- R11: Writing 1s to address 6 sets those enable bits, and writing 1s to address 7 clears them. The enable bits use the same positions as status: bit 0 compare, bit 1 overflow, bit 2 capture.
- R12: The interrupt output is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Waveform / general-purpose output pin |
| irq | output | 1 | Interrupt request |

## Verification
A wrong tick count or a missed wrap shows up in the counter readback within the same window that produced it. A prescaler off by one period drifts by a whole count after 2^(r+1) clocks. A lost overflow or compare flag appears on the status readback one clock after the tick. It also shows in the run bit and on the pin, because toggle state and pulse timing both key off the same events. Capture faults appear a few clocks after the input edge, once the synchroniser has drained, as a wrong or stale capture value and a missing or spurious status bit 2.

// File: rtl/tmr_pkg.sv
// Package: shared constants for the compare/capture timer.
// Assumes: bit positions below are software-visible and must not move.
package tmr_pkg;
    localparam int CTRL_W   = 15;
    localparam int RATIO_W  = 3;
    localparam int EVT_W    = 3;

    // control field positions
    localparam int C_RUN    = 0;
    localparam int C_RELOAD = 1;
    localparam int C_RATIO  = 2;
    localparam int C_PREEN  = 5;
    localparam int C_CMPEN  = 6;
    localparam int C_IDLE   = 7;
    localparam int C_EDGE   = 8;
    localparam int C_TRIG   = 10;
    localparam int C_TOGGLE = 12;
    localparam int C_HOLD   = 13;
    localparam int C_GPO    = 14;

    // event bit positions in status and enable vectors
    localparam int E_MATCH  = 0;
    localparam int E_OVF    = 1;
    localparam int E_CAPT   = 2;

    // register word addresses
    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_CNT   = 4'd1;
    localparam logic [3:0] A_LOAD  = 4'd2;
    localparam logic [3:0] A_CMP   = 4'd3;
    localparam logic [3:0] A_CAPT  = 4'd4;
    localparam logic [3:0] A_STAT  = 4'd5;
    localparam logic [3:0] A_ENSET = 4'd6;
    localparam logic [3:0] A_ENCLR = 4'd7;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_OVF  = 2'd1,
        TRIG_BOTH = 2'd2,
        TRIG_RSVD = 2'd3
    } trig_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tick generator. With the divider off every running clock is a
// tick; with it on, one tick per 2^(ratio+1) clocks.
// Assumes: restart is a one-clock pulse on control writes.
module tmr_prescaler #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               pre_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               restart,
    output logic               tick
);
    localparam int PC_W = 1 << RATIO_W;

    logic [PC_W-1:0] div_q;
    logic [PC_W-1:0] last;

    // terminal divider value for the selected ratio
    always_comb last = (PC_W'(2) << ratio) - PC_W'(1);

    // tick decision for this clock
    always_comb tick = run && (!pre_en || (div_q == last));

    // divider count, restarted on control writes or while halted
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            div_q <= '0;
        end else if (pre_en) begin
            div_q <= (div_q == last) ? '0 : div_q + PC_W'(1);
        end
    end
endmodule

// File: rtl/tmr_counter.sv
// Module: main up-counter with wrap handling and compare detection.
// Assumes: a software write and a tick in one clock resolve to the write.
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reload_en,
    input  logic [W-1:0] load_val,
    input  logic         cmp_en,
    input  logic [W-1:0] cmp_val,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] count,
    output logic         ovf_evt,
    output logic         match_evt,
    output logic         stop_req
);
    logic at_max;

    // event decode from the value held before this tick
    always_comb begin
        at_max    = &count;
        ovf_evt   = tick && at_max;
        match_evt = tick && cmp_en && (count == cmp_val);
        stop_req  = ovf_evt && !reload_en;
    end

    // counter register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_cnt) begin
            count <= wr_val;
        end else if (tick) begin
            if (at_max) begin
                count <= reload_en ? load_val : '0;
            end else begin
                count <= count + W'(1);
            end
        end
    end
endmodule

// File: rtl/tmr_capture.sv
// Module: input synchroniser, edge selector and capture register.
// Assumes: cap_in is asynchronous; SYNC_ST >= 1 flops precede detection.
module tmr_capture #(
    parameter int W       = 32,
    parameter int SYNC_ST = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  logic [1:0]   edge_sel,
    input  logic         hold_mode,
    input  logic         flag_set,
    input  logic [W-1:0] count,
    output logic [W-1:0] cap_val,
    output logic         cap_evt
);
    logic [SYNC_ST-1:0] sync_q;
    logic               prev_q;
    logic               cur;
    logic               rise;
    logic               fall;
    logic               store;

    generate
        if (SYNC_ST == 1) begin : g_sync1
            // single-stage synchroniser
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= cap_in;
            end
        end else begin : g_syncn
            // multi-stage synchroniser shift chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_ST-2:0], cap_in};
            end
        end
    endgenerate

    // previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_ST-1];
    end

    // edge qualification against the selected polarity
    always_comb begin
        cur     = sync_q[SYNC_ST-1];
        rise    = cur && !prev_q;
        fall    = !cur && prev_q;
        cap_evt = (edge_sel[0] && rise) || (edge_sel[1] && fall);
        store   = cap_evt && !(hold_mode && flag_set);
    end

    // capture register load
    always_ff @(posedge clk) begin
        if (!rst_n)     cap_val <= '0;
        else if (store) cap_val <= count;
    end
endmodule

// File: rtl/tmr_outgen.sv
// Module: output pin generator with toggle and one-clock pulse styles.
// Assumes: events are single-clock strobes from the counter.
module tmr_outgen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       ovf_evt,
    input  logic       match_evt,
    input  logic [1:0] trig_sel,
    input  logic       toggle_mode,
    input  logic       idle_lvl,
    input  logic       gpo_mode,
    output logic       pin
);
    import tmr_pkg::*;

    logic evt;
    logic tog_q;
    logic pulse_q;

    // event selection by trigger mode
    always_comb begin
        unique case (trig_e'(trig_sel))
            TRIG_OVF:  evt = ovf_evt;
            TRIG_BOTH: evt = ovf_evt || match_evt;
            default:   evt = 1'b0;
        endcase
    end

    // toggle and pulse state
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tog_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            tog_q   <= tog_q ^ evt;
            pulse_q <= evt;
        end
    end

    // pin level
    always_comb begin
        if (gpo_mode) pin = idle_lvl;
        else          pin = idle_lvl ^ (toggle_mode ? tog_q : pulse_q);
    end
endmodule

// File: rtl/cmp_cap_timer.sv
// Module: top of the compare/capture timer: register file, status and
// enable vectors, interrupt, and the counting datapath.
// Assumes: single-cycle register writes, combinational reads, one clock.
module cmp_cap_timer #(
    parameter int W       = 32,
    parameter int SYNC_ST = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [3:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         cap_in,
    output logic         pwm_out,
    output logic         irq
);
    import tmr_pkg::*;

    logic [CTRL_W-1:0] ctrl_q;
    logic [W-1:0]      load_q;
    logic [W-1:0]      cmp_q;
    logic [EVT_W-1:0]  stat_q;
    logic [EVT_W-1:0]  en_q;
    logic [W-1:0]      count;
    logic [W-1:0]      cap_val;
    logic              tick;
    logic              ovf_evt;
    logic              match_evt;
    logic              cap_evt;
    logic              stop_req;
    logic              wr_ctrl;
    logic              wr_cnt;
    logic [EVT_W-1:0]  hw_evt;

    // write strobes per register
    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_cnt  = wr_en && (addr == A_CNT);
        hw_evt  = '0;
        hw_evt[E_MATCH] = match_evt;
        hw_evt[E_OVF]   = ovf_evt;
        hw_evt[E_CAPT]  = cap_evt;
    end

    // control register; hardware clears run after a non-reloading wrap
    always_ff @(posedge clk) begin
        if (!rst_n)          ctrl_q <= '0;
        else if (wr_ctrl)    ctrl_q <= wdata[CTRL_W-1:0];
        else if (stop_req)   ctrl_q[C_RUN] <= 1'b0;
    end

    // load and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_LOAD) load_q <= wdata;
            if (addr == A_CMP)  cmp_q  <= wdata;
        end
    end

    // sticky status with write-one-to-clear; new events win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (wr_en && (addr == A_STAT)) begin
            stat_q <= (stat_q & ~wdata[EVT_W-1:0]) | hw_evt;
        end else begin
            stat_q <= stat_q | hw_evt;
        end
    end

    // enable mask through separate set and clear addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && (addr == A_ENSET)) begin
            en_q <= en_q | wdata[EVT_W-1:0];
        end else if (wr_en && (addr == A_ENCLR)) begin
            en_q <= en_q & ~wdata[EVT_W-1:0];
        end
    end

    // read multiplexer
    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            A_CNT:   rdata = count;
            A_LOAD:  rdata = load_q;
            A_CMP:   rdata = cmp_q;
            A_CAPT:  rdata = cap_val;
            A_STAT:  rdata = {{(W-EVT_W){1'b0}}, stat_q};
            A_ENSET,
            A_ENCLR: rdata = {{(W-EVT_W){1'b0}}, en_q};
            default: rdata = '0;
        endcase
    end

    // interrupt request from masked status
    always_comb irq = |(stat_q & en_q);

    tmr_prescaler #(.RATIO_W(RATIO_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q[C_RUN]),
        .pre_en  (ctrl_q[C_PREEN]),
        .ratio   (ctrl_q[C_RATIO +: RATIO_W]),
        .restart (wr_ctrl),
        .tick    (tick)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reload_en (ctrl_q[C_RELOAD]),
        .load_val  (load_q),
        .cmp_en    (ctrl_q[C_CMPEN]),
        .cmp_val   (cmp_q),
        .wr_cnt    (wr_cnt),
        .wr_val    (wdata),
        .count     (count),
        .ovf_evt   (ovf_evt),
        .match_evt (match_evt),
        .stop_req  (stop_req)
    );

    tmr_capture #(.W(W), .SYNC_ST(SYNC_ST)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_in    (cap_in),
        .edge_sel  (ctrl_q[C_EDGE +: 2]),
        .hold_mode (ctrl_q[C_HOLD]),
        .flag_set  (stat_q[E_CAPT]),
        .count     (count),
        .cap_val   (cap_val),
        .cap_evt   (cap_evt)
    );

    tmr_outgen u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (wr_ctrl),
        .ovf_evt     (ovf_evt),
        .match_evt   (match_evt),
        .trig_sel    (ctrl_q[C_TRIG +: 2]),
        .toggle_mode (ctrl_q[C_TOGGLE]),
        .idle_lvl    (ctrl_q[C_IDLE]),
        .gpo_mode    (ctrl_q[C_GPO]),
        .pin         (pwm_out)
    );
endmodule

// File: rtl/tmr_checker.sv
// Module: temporal checks on the timer, attached to the top by bind.
// Assumes: internal signals are connected by name in the bind below.
module tmr_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [3:0]   addr,
    input logic         tick,
    input logic [W-1:0] count,
    input logic [W-1:0] load_q,
    input logic         run,
    input logic         reload,
    input logic [2:0]   stat_q,
    input logic [2:0]   en_q,
    input logic         irq
);
    import tmr_pkg::*;

    logic wr_cnt;
    logic wr_ctl;
    logic wr_ld;
    always_comb begin
        wr_cnt = wr_en && (addr == A_CNT);
        wr_ctl = wr_en && (addr == A_CTRL);
        wr_ld  = wr_en && (addr == A_LOAD);
    end

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(count));                         // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(&count) && !wr_cnt) |=> (count == $past(count) + W'(1))); // R2
    AST_WRAP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count) && !reload && !wr_cnt && !wr_ctl) |=> (count == '0 && !run)); // R4
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count) && reload && !wr_cnt && !wr_ld) |=> (count == $past(load_q))); // R4
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count)) |=> stat_q[E_OVF]);                          // R4
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);                                         // R12
endmodule

bind cmp_cap_timer tmr_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .tick   (tick),
    .count  (count),
    .load_q (load_q),
    .run    (ctrl_q[0]),
    .reload (ctrl_q[1]),
    .stat_q (stat_q),
    .en_q   (en_q),
    .irq    (irq)
);

// File: tb/tb_cmp_cap_timer.sv
module tb_cmp_cap_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        cap_in = 1'b0;
    logic        pwm_out;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cmp_cap_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] init;
        logic [31:0] load;
        logic [31:0] cmp;
        logic [15:0] ctrl;
        logic [7:0]  n;
        logic [31:0] exp_cnt;
        logic [2:0]  exp_stat;
        logic        exp_run;
    } vec_t;

    // stimulus / expected vectors: start value, load, compare, control,
    // clocks to run, then expected counter, status and run bit
    localparam vec_t VECS [8] = '{
        '{32'd100,        32'd0, 32'd0,          16'h0001, 8'd5,  32'd105, 3'b000, 1'b1}, // R2
        '{32'd0,          32'd0, 32'd0,          16'h0021, 8'd7,  32'd3,   3'b000, 1'b1}, // R3 r=0
        '{32'd0,          32'd0, 32'd0,          16'h0029, 8'd20, 32'd2,   3'b000, 1'b1}, // R3 r=2
        '{32'hFFFFFFFE,   32'd0, 32'd0,          16'h0001, 8'd3,  32'd0,   3'b010, 1'b0}, // R4 stop
        '{32'hFFFFFFFE,   32'd5, 32'd0,          16'h0003, 8'd3,  32'd6,   3'b010, 1'b1}, // R4 reload
        '{32'd8,          32'd0, 32'd10,         16'h0041, 8'd4,  32'd12,  3'b001, 1'b1}, // R5
        '{32'd8,          32'd0, 32'd10,         16'h0001, 8'd4,  32'd12,  3'b000, 1'b1}, // R5 off
        '{32'hFFFFFFFE,   32'd0, 32'hFFFFFFFF,   16'h0043, 8'd3,  32'd1,   3'b011, 1'b1}  // R4 R5
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic prep(input logic [31:0] init, input logic [31:0] ld, input logic [31:0] cm);
        wr(4'd0, 32'd0);
        wr(4'd5, 32'd7);
        wr(4'd2, ld);
        wr(4'd3, cm);
        wr(4'd1, init);
    endtask

    task automatic edge_wait(input logic lvl);
        @(negedge clk);
        cap_in = lvl;
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            chk("R1 reset reg", d, 32'd0);
        end
        chk("R1 reset pin", {31'd0, pwm_out}, 32'd0);
        chk("R1 reset irq", {31'd0, irq}, 32'd0);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < 8; i++) begin
            prep(VECS[i].init, VECS[i].load, VECS[i].cmp);
            wr(4'd0, {16'd0, VECS[i].ctrl});
            repeat (int'(VECS[i].n)) @(posedge clk);
            @(negedge clk);
            rd(4'd1, d); chk("R2/R3/R4 count", d, VECS[i].exp_cnt);
            rd(4'd5, d); chk("R4/R5 status", d, {29'd0, VECS[i].exp_stat});
            rd(4'd0, d); chk("R4 run bit", {31'd0, d[0]}, {31'd0, VECS[i].exp_run});
        end

        // R8 toggle on overflow with reload
        prep(32'hFFFFFFFE, 32'hFFFFFFFE, 32'd0);
        wr(4'd0, 32'h1403);
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R8 toggle ovf first", {31'd0, pwm_out}, 32'd1);
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R8 toggle ovf second", {31'd0, pwm_out}, 32'd0);

        // R8 toggle on overflow and compare
        prep(32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFE);
        wr(4'd0, 32'h1843);
        @(posedge clk); @(negedge clk);
        chk("R8 toggle on compare", {31'd0, pwm_out}, 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R8 toggle on ovf", {31'd0, pwm_out}, 32'd0);

        // R8 trigger none: no change
        prep(32'hFFFFFFFE, 32'hFFFFFFFE, 32'd0);
        wr(4'd0, 32'h1003);
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R8 trigger none", {31'd0, pwm_out}, 32'd0);

        // R8 pulse mode: one-clock inversion
        prep(32'hFFFFFFFE, 32'd0, 32'd0);
        wr(4'd0, 32'h0401);
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R8 pulse high", {31'd0, pwm_out}, 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R8 pulse ends", {31'd0, pwm_out}, 32'd0);

        // R9 idle level and forced output
        wr(4'd0, 32'h0080); @(negedge clk);
        chk("R9 idle level", {31'd0, pwm_out}, 32'd1);
        wr(4'd0, 32'h4000); @(negedge clk);
        chk("R9 gpo low", {31'd0, pwm_out}, 32'd0);
        wr(4'd0, 32'h4080); @(negedge clk);
        chk("R9 gpo high", {31'd0, pwm_out}, 32'd1);

        // R10 R11 R12 status, enables, interrupt
        prep(32'hFFFFFFFF, 32'd0, 32'd0);
        wr(4'd0, 32'h0001);
        @(posedge clk); @(negedge clk);
        rd(4'd5, d); chk("R4 ovf flag", d, 32'd2);
        chk("R12 irq masked", {31'd0, irq}, 32'd0);
        wr(4'd6, 32'd2); @(negedge clk);
        chk("R11 R12 irq enabled", {31'd0, irq}, 32'd1);
        rd(4'd7, d); chk("R11 enable readback", d, 32'd2);
        wr(4'd6, 32'd1); @(negedge clk);
        rd(4'd6, d); chk("R11 set keeps others", d, 32'd3);
        wr(4'd7, 32'd2); @(negedge clk);
        chk("R11 R12 irq disabled", {31'd0, irq}, 32'd0);
        rd(4'd6, d); chk("R11 clear one bit", d, 32'd1);
        wr(4'd5, 32'd0); @(negedge clk);
        rd(4'd5, d); chk("R10 write zero keeps", d, 32'd2);
        wr(4'd6, 32'd2); @(negedge clk);
        wr(4'd5, 32'd2); @(negedge clk);
        rd(4'd5, d); chk("R10 w1c clears", d, 32'd0);
        chk("R12 irq drops with status", {31'd0, irq}, 32'd0);

        // R6 capture rising edge
        prep(32'h1234, 32'd0, 32'd0);
        wr(4'd0, 32'h0100);
        edge_wait(1'b1);
        rd(4'd4, d); chk("R6 rise capture", d, 32'h1234);
        rd(4'd5, d); chk("R6 rise flag", d, 32'd4);
        wr(4'd5, 32'd7); wr(4'd1, 32'h2222);
        edge_wait(1'b0);
        rd(4'd4, d); chk("R6 fall ignored value", d, 32'h1234);
        rd(4'd5, d); chk("R6 fall ignored flag", d, 32'd0);
        // R6 both edges
        wr(4'd0, 32'h0300);
        edge_wait(1'b1);
        rd(4'd4, d); chk("R6 both rise", d, 32'h2222);
        wr(4'd5, 32'd7); wr(4'd1, 32'h3333);
        edge_wait(1'b0);
        rd(4'd4, d); chk("R6 both fall", d, 32'h3333);
        rd(4'd5, d); chk("R6 both fall flag", d, 32'd4);
        // R6 no edge selected
        wr(4'd0, 32'h0000); wr(4'd5, 32'd7); wr(4'd1, 32'h4444);
        edge_wait(1'b1);
        rd(4'd4, d); chk("R6 none value", d, 32'h3333);
        rd(4'd5, d); chk("R6 none flag", d, 32'd0);
        edge_wait(1'b0);
        // R7 hold mode
        wr(4'd0, 32'h2100); wr(4'd5, 32'd7); wr(4'd1, 32'h5555);
        edge_wait(1'b1);
        rd(4'd4, d); chk("R7 first capture", d, 32'h5555);
        edge_wait(1'b0);
        wr(4'd1, 32'h6666);
        edge_wait(1'b1);
        rd(4'd4, d); chk("R7 held while flagged", d, 32'h5555);
        rd(4'd5, d); chk("R7 flag still set", d, 32'd4);
        wr(4'd5, 32'd4);
        edge_wait(1'b0);
        edge_wait(1'b1);
        rd(4'd4, d); chk("R7 capture after clear", d, 32'h6666);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule